// File: doc/BRIEF.md
# Split-Mode Event Counter Bank with Staged Writes

This block holds a small set of physical event counters that software reaches over a simple 64-bit register bus. Each physical counter either runs as one 32-bit counter or is cut into two independent 16-bit counters, so one physical counter serves two logical counters. With `NPHYS` physical counters there are `2*NPHYS` logical counter numbers and one event input per logical number.

A counter write never touches the running count directly. It fills a holding latch and raises a pending flag. The latch is copied into the live counter only when the control register is written with its enable bit set, and this also happens when the unit is already running. While a counter is pending, a read of it returns the latch.

Wraps set sticky status bits. A read of the status register clears them. A write to the status register loads an interrupt mask, and the interrupt output is the OR of the masked status bits.

Top module: `split_ctr_bank`

## Requirements
- R1: After reset the control word, status bits, interrupt mask, every live counter and every pending flag are zero, and `irq` is low.
- R2: A physical counter p in 32-bit mode adds one on each cycle in which the enable bit (control bit 0) is set and `evt_in[p]` is high. It ignores `evt_in[p+NPHYS]`. No counter changes while enable is clear.
- R3: Control bit 1+p set puts physical counter p in 16-bit mode. Its upper half counts `evt_in[p]` and its lower half counts `evt_in[p+NPHYS]`. A wrap of the lower half never carries into the upper half.
- R4: A write to logical counter l (address 16+l) loads only the holding latch of physical counter l mod NPHYS and sets its pending flag. A read of a pending counter returns the latch value, and otherwise returns the live value.
- R5: A write to the control register (address 0) with bit 0 set copies every pending latch into its live counter and clears all pending flags. This also happens when the unit is already enabled.
- R6: In 16-bit mode, a write to logical l < NPHYS replaces the upper half of the readable value and keeps the lower half. A write to l >= NPHYS replaces the lower half and keeps the upper half. A read returns the selected half in bits 15:0 with the upper bits zero. In 32-bit mode both logical numbers of a physical counter reach the whole 32 bits.
- R7: Register data sits in bits 63:32 of the bus word. Bits 31:0 are ignored on writes and read as zero. Read data and `bus_rvalid` appear on the clock edge after the one that samples `bus_rd`.
- R8: A wrap from all-ones to zero sets a status bit. A 32-bit counter p or an upper half p sets bit p, and a lower half p sets bit p+NPHYS.
- R9: A read of the status register (address 1) returns the status bits and clears them. An overflow that lands in the same cycle as that read stays set afterwards.
- R10: A write to address 1 loads the interrupt mask. `irq` is high exactly when some status bit is set whose mask bit is set, so a zero mask keeps `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 64 | Write data, register in bits 63:32 |
| bus_rdata | output | 64 | Registered read data, register in bits 63:32 |
| bus_rvalid | output | 1 | Read data valid, one cycle after the read strobe |
| evt_in | input | 2*NPHYS | One event input per logical counter |
| irq | output | 1 | Masked overflow interrupt |

## Verification
The hardest case to reach from the ports is a status read that meets a fresh overflow in the same cycle. To get there, the stimulus preloads a 32-bit counter with all-ones through the latch, commits it, and then raises that counter's event in the very cycle that carries the status read strobe. The read must return the old status, and a second read must return the new bit. A second hard case is a latch commit while the unit is already counting: the bench lets the live count drift under a pending write, checks that reads still show the latch, and then rewrites the control register.

// File: rtl/split_ctr_pkg.sv
package split_ctr_pkg;
  localparam int ADDR_CTRL = 0;
  localparam int ADDR_STAT = 1;
  localparam int CTR_BASE  = 16;
  localparam int REG_W     = 32;
  localparam int BUS_W     = 64;
endpackage

// File: rtl/split_ctr_slice.sv
module split_ctr_slice #(
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_en,
  input  logic          split,
  input  logic          evt_hi,
  input  logic          evt_lo,
  input  logic          wr_full,
  input  logic          wr_hi,
  input  logic          wr_lo,
  input  logic [CW-1:0] wval,
  input  logic          commit,
  output logic [CW-1:0] rd_val,
  output logic          pending,
  output logic          ovf_hi,
  output logic          ovf_lo
);
  localparam int HW = CW / 2;

  logic [CW-1:0] live_q, live_d, latch_q, latch_d;
  logic          pend_q, pend_d;
  logic          wr_any, load;

  assign wr_any  = wr_full | wr_hi | wr_lo;
  assign load    = commit & pend_q;
  assign rd_val  = pend_q ? latch_q : live_q;
  assign pending = pend_q;

  always_comb begin
    latch_d = latch_q;
    if (wr_full)    latch_d = wval;
    else if (wr_hi) latch_d = {wval[HW-1:0], rd_val[HW-1:0]};
    else if (wr_lo) latch_d = {rd_val[CW-1:HW], wval[HW-1:0]};
  end

  always_comb begin
    pend_d = pend_q;
    if (commit)      pend_d = 1'b0;
    else if (wr_any) pend_d = 1'b1;
  end

  always_comb begin
    live_d = live_q;
    ovf_hi = 1'b0;
    ovf_lo = 1'b0;
    if (load) begin
      live_d = latch_q;
    end else if (cnt_en) begin
      if (split) begin
        if (evt_hi) begin
          live_d[CW-1:HW] = live_q[CW-1:HW] + 1'b1;
          ovf_hi          = &live_q[CW-1:HW];
        end
        if (evt_lo) begin
          live_d[HW-1:0] = live_q[HW-1:0] + 1'b1;
          ovf_lo         = &live_q[HW-1:0];
        end
      end else if (evt_hi) begin
        live_d = live_q + 1'b1;
        ovf_hi = &live_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) latch_q <= '0;
    else if (wr_any) latch_q <= latch_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      live_q <= '0;
      pend_q <= 1'b0;
    end else begin
      live_q <= live_d;
      pend_q <= pend_d;
    end
  end

  // R3
  no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (split && !evt_hi && !load) |=> (live_q[CW-1:HW] == $past(live_q[CW-1:HW])));
  // R5
  pend_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !pend_q);
  // R5
  commit_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (live_q == $past(latch_q)));
  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !commit) |=> $stable(live_q));
endmodule

// File: rtl/split_ctr_status.sv
module split_ctr_status #(
  parameter int NL = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NL-1:0] ovf,
  input  logic          rd_clr,
  input  logic          mask_wr,
  input  logic [NL-1:0] wmask,
  output logic [NL-1:0] status,
  output logic          irq
);
  logic [NL-1:0] stat_q, stat_d, mask_q;

  always_comb begin
    stat_d = rd_clr ? '0 : stat_q;
    stat_d = stat_d | ovf;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stat_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_wr) mask_q <= wmask;
  end

  assign status = stat_q;
  assign irq    = |(stat_q & mask_q);

  // R8
  sticky_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf != '0) |=> ((stat_q & $past(ovf)) == $past(ovf)));
  // R9
  rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && ovf == '0) |=> (stat_q == '0));
endmodule

// File: rtl/split_ctr_bank.sv
module split_ctr_bank
  import split_ctr_pkg::*;
#(
  parameter int NPHYS  = 4,
  parameter int CW     = 32,
  parameter int ADDR_W = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [63:0]          bus_wdata,
  output logic [63:0]          bus_rdata,
  output logic                 bus_rvalid,
  input  logic [2*NPHYS-1:0]   evt_in,
  output logic                 irq
);
  localparam int NL = 2 * NPHYS;
  localparam int PW = $clog2(NPHYS);
  localparam int LW = PW + 1;
  localparam int HW = CW / 2;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(ADDR_CTRL);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADDR_STAT);
  localparam logic [ADDR_W-1:0] A_BASE = ADDR_W'(CTR_BASE);

  logic [REG_W-1:0]  wreg;
  logic              unused_lo;
  logic              ctrl_en_q;
  logic [NPHYS-1:0]  ctrl_split_q;
  logic              ctrl_wr, commit, stat_rd, mask_wr;
  logic [ADDR_W-1:0] off;
  logic              in_ctr;
  logic [LW-1:0]     l_idx;
  logic [PW-1:0]     p_idx;
  logic [NL-1:0]     ctr_hit;
  logic [NL-1:0]     ovf, status;
  logic [CW-1:0]     rdv [NPHYS];
  logic [NPHYS-1:0]  pend;
  logic [REG_W-1:0]  rd_word;
  logic [63:0]       rdata_q;
  logic              rvalid_q;

  assign wreg      = bus_wdata[63:32];
  assign unused_lo = ^{bus_wdata[31:0], pend};

  assign ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  assign commit  = ctrl_wr && wreg[0];
  assign mask_wr = bus_wr && (bus_addr == A_STAT);
  assign stat_rd = bus_rd && (bus_addr == A_STAT);

  assign off    = bus_addr - A_BASE;
  assign in_ctr = (bus_addr >= A_BASE) && (off < ADDR_W'(NL));
  assign l_idx  = off[LW-1:0];
  assign p_idx  = l_idx[PW-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_en_q    <= 1'b0;
      ctrl_split_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_en_q    <= wreg[0];
      ctrl_split_q <= wreg[NPHYS:1];
    end
  end

  genvar gl;
  generate
    for (gl = 0; gl < NL; gl++) begin : g_hit
      assign ctr_hit[gl] = bus_wr && in_ctr && (l_idx == LW'(gl));
    end
  endgenerate

  genvar gp;
  generate
    for (gp = 0; gp < NPHYS; gp++) begin : g_slice
      logic wr_full, wr_hi, wr_lo;
      assign wr_full = (ctr_hit[gp] | ctr_hit[gp+NPHYS]) & ~ctrl_split_q[gp];
      assign wr_hi   = ctr_hit[gp] & ctrl_split_q[gp];
      assign wr_lo   = ctr_hit[gp+NPHYS] & ctrl_split_q[gp];

      split_ctr_slice #(.CW(CW)) u_slice (
        .clk     (clk),
        .rst_n   (rst_n),
        .cnt_en  (ctrl_en_q),
        .split   (ctrl_split_q[gp]),
        .evt_hi  (evt_in[gp]),
        .evt_lo  (evt_in[gp+NPHYS]),
        .wr_full (wr_full),
        .wr_hi   (wr_hi),
        .wr_lo   (wr_lo),
        .wval    (wreg[CW-1:0]),
        .commit  (commit),
        .rd_val  (rdv[gp]),
        .pending (pend[gp]),
        .ovf_hi  (ovf[gp]),
        .ovf_lo  (ovf[gp+NPHYS])
      );
    end
  endgenerate

  split_ctr_status #(.NL(NL)) u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .ovf     (ovf),
    .rd_clr  (stat_rd),
    .mask_wr (mask_wr),
    .wmask   (wreg[NL-1:0]),
    .status  (status),
    .irq     (irq)
  );

  always_comb begin
    rd_word = '0;
    if (bus_addr == A_CTRL) begin
      rd_word[NPHYS:0] = {ctrl_split_q, ctrl_en_q};
    end else if (bus_addr == A_STAT) begin
      rd_word[NL-1:0] = status;
    end else if (in_ctr) begin
      if (ctrl_split_q[p_idx]) begin
        rd_word[HW-1:0] = l_idx[PW] ? rdv[p_idx][HW-1:0] : rdv[p_idx][CW-1:HW];
      end else begin
        rd_word[CW-1:0] = rdv[p_idx];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else if (bus_rd) rdata_q <= {rd_word, 32'h0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rvalid_q <= 1'b0;
    else        rvalid_q <= bus_rd;
  end

  assign bus_rdata  = rdata_q;
  assign bus_rvalid = rvalid_q;

  // R7
  rdata_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> (bus_rdata[31:0] == 32'h0));
  // R7
  rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
endmodule

// File: tb/split_ctr_bank_test.sv
`timescale 1ns/100ps
module split_ctr_bank_test;
  localparam int N  = 4;
  localparam int NL = 2 * N;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    bus_addr = '0;
  logic          bus_wr = 1'b0;
  logic          bus_rd = 1'b0;
  logic [63:0]   bus_wdata = '0;
  logic [63:0]   bus_rdata;
  logic          bus_rvalid;
  logic [NL-1:0] evt_in = '0;
  logic          irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  typedef struct {
    logic [63:0] val;
    string       tag;
  } exp_t;
  exp_t exp_q[$];

  always #2.5 clk = ~clk;

  split_ctr_bank #(.NPHYS(N), .CW(32), .ADDR_W(6)) uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .evt_in(evt_in), .irq(irq)
  );

  // monitor: pops an expected read item per valid read
  always @(negedge clk) begin
    if (bus_rvalid && !done) begin
      exp_t e;
      n_tests++;
      if (exp_q.size() == 0) begin
        n_fail++;
        $display("FAIL unexpected read data actual=%h expected=none", bus_rdata);
      end else begin
        e = exp_q.pop_front();
        if (bus_rdata !== e.val) begin
          n_fail++;
          $display("FAIL %s actual=%h expected=%h", e.tag, bus_rdata, e.val);
        end
      end
    end
  end

  task automatic check_bit(input logic act, input logic exp, input string tag);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wr    = 1'b1;
    bus_wdata = {d, 32'hA5A5_5A5A};
    @(negedge clk);
    bus_wr    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] exp, input string tag,
                    input logic [NL-1:0] ev = '0);
    @(negedge clk);
    bus_addr = a;
    bus_rd   = 1'b1;
    evt_in   = ev;
    exp_q.push_back('{val: {exp, 32'h0}, tag: tag});
    @(negedge clk);
    bus_rd = 1'b0;
    evt_in = '0;
  endtask

  task automatic pulse(input logic [NL-1:0] ev, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      evt_in = ev;
    end
    @(negedge clk);
    evt_in = '0;
  endtask

  initial begin
    #200000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_bit(irq, 1'b0, "R1 irq after reset");
    rd(6'd0, 32'h0, "R1 control reset");
    rd(6'd1, 32'h0, "R1 status reset");
    rd(6'd16, 32'h0, "R1 counter reset");

    // R4 staged write, R7 low word ignored and read as zero
    wr(6'd16, 32'h0000_0100);
    rd(6'd16, 32'h0000_0100, "R4 R7 pending latch read");
    pulse(8'h01, 3);                       // disabled: no effect
    // R5 commit on enable
    wr(6'd0, 32'h1);
    rd(6'd16, 32'h0000_0100, "R5 committed value");
    rd(6'd0, 32'h1, "R5 control readback");

    // R2 counting in 32-bit mode
    pulse(8'h01, 5);
    rd(6'd16, 32'h0000_0105, "R2 five events");
    pulse(8'h10, 3);                       // upper logical event ignored
    rd(6'd16, 32'h0000_0105, "R2 second logical event ignored");
    rd(6'd20, 32'h0000_0105, "R6 32-bit alias of logical 4");
    wr(6'd0, 32'h0);
    pulse(8'h01, 3);
    rd(6'd16, 32'h0000_0105, "R2 no count while disabled");

    // R5 commit while already enabled
    wr(6'd0, 32'h1);
    wr(6'd17, 32'h55);
    pulse(8'h02, 2);
    rd(6'd17, 32'h55, "R4 pending read hides live count");
    wr(6'd0, 32'h1);
    rd(6'd17, 32'h55, "R5 re-enable commits");
    pulse(8'h02, 1);
    rd(6'd17, 32'h56, "R5 counting after commit");

    // R6 split writes on physical 2, control = enable | split2 (bit 3)
    wr(6'd0, 32'h9);
    wr(6'd22, 32'hFFFF);
    wr(6'd18, 32'h1234);
    rd(6'd18, 32'h1234, "R6 upper half write");
    rd(6'd22, 32'hFFFF, "R6 lower half kept");
    wr(6'd0, 32'h9);
    wr(6'd1, 32'h40);                      // R10 mask bit 6
    check_bit(irq, 1'b0, "R10 no irq before overflow");
    pulse(8'h40, 1);                       // lower half wraps
    check_bit(irq, 1'b1, "R10 irq on masked overflow");
    rd(6'd22, 32'h0, "R3 lower half wrapped");
    rd(6'd18, 32'h1234, "R3 no carry into upper half");
    rd(6'd1, 32'h40, "R8 lower half status bit");
    check_bit(irq, 1'b0, "R9 irq low after clearing read");
    rd(6'd1, 32'h0, "R9 status cleared");
    pulse(8'h04, 1);
    rd(6'd18, 32'h1235, "R3 upper half counts its own event");

    // R9 overflow in the same cycle as a status read (physical 3, 32-bit)
    wr(6'd19, 32'hFFFF_FFFF);
    wr(6'd0, 32'h9);
    rd(6'd1, 32'h0, "R9 read returns old status", 8'h08);
    rd(6'd1, 32'h8, "R9 same-cycle overflow kept");

    // R10 zero mask suppresses irq
    wr(6'd1, 32'h0);
    wr(6'd23, 32'hFFFF_FFFF);
    wr(6'd0, 32'h9);
    pulse(8'h08, 1);
    check_bit(irq, 1'b0, "R10 zero mask keeps irq low");
    rd(6'd1, 32'h8, "R8 32-bit wrap status bit");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_tests++;
      n_fail++;
      $display("FAIL R7 missing reads actual=%0d expected=0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule